// File: doc/BRIEF.md
# Convolutional Symbol Deinterleaver

The block undoes the symbol permutation applied by a matching convolutional interleaver. Accepted input symbols are handed out one at a time to `NUM_BR` delay branches, one branch per symbol, by a rotating selector. Branch `j` (counted from 0) holds `(NUM_BR-1-j)*STEP` symbols. The last branch has no storage and passes its symbol straight through. After the pipeline fills, each symbol leaves in the position it had before interleaving. The interleaver must use the same `NUM_BR` and `STEP`.

Symbols are complex. Each one is carried as a real field and an imaginary field of `DATA_W` bits. Both fields share the branch storage and the branch pointers. A real-only stream ties the imaginary input to zero. Every delaying branch starts with a known fill value, which is loaded again at each reset. The fill is either one common value for all delaying branches or its own value for each branch. A parameter selects which. The output rate equals the input rate: every accepted symbol produces exactly one output one cycle later. Cycles with `din_vld_i` low (stalls) change nothing.

Top module: `cdi_deinterleaver`

## Requirements
- R1: Let `m` be the index of an accepted input, counted from 0 after reset, and let `j = m mod NUM_BR` be its branch. The output for input `m` is the symbol accepted at input `m - NUM_BR*(NUM_BR-1-j)*STEP` when that index is 0 or more.
- R2: The last branch (`j = NUM_BR-1`) has no delay. Its output equals the symbol accepted in the previous cycle, for both fields.
- R3: The branch selector starts at branch 0 after reset. It advances by one branch for each accepted symbol and wraps from branch `NUM_BR-1` back to branch 0.
- R4: A cycle with `din_vld_i` low moves no pointer and changes no stored symbol, whatever data is on the inputs. The outputs keep their values during that cycle.
- R5: `dout_vld_o` is high exactly in the cycle after a cycle with `din_vld_i` high. Reset drives `dout_vld_o`, `dout_re_o` and `dout_im_o` to 0.
- R6: With `USE_SCALAR=0`, an output whose source index from R1 would be negative carries entry `j` of `INIT_VEC`. Entry `j` sits at bits `[j*2*DATA_W +: 2*DATA_W]`, with the real part in the upper `DATA_W` bits. Entry `NUM_BR-1` never appears at the output.
- R7: With `USE_SCALAR=1`, such outputs carry `INIT_SCALAR` (real part in the upper `DATA_W` bits) on every delaying branch.
- R8: Feed the block from a convolutional interleaver whose branch `j` delays by `j*STEP`. Input `m` of that interleaver then reappears at output `m + NUM_BR*(NUM_BR-1)*STEP`.
- R9: The real and imaginary fields follow identical delays through the same branch.
- R10: A reset in the middle of a stream reloads all fill values and restarts the selector at branch 0. The next outputs follow R6 or R7 from index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| din_vld_i | input | 1 | Input symbol is valid |
| din_re_i | input | DATA_W | Input real field |
| din_im_i | input | DATA_W | Input imaginary field |
| dout_vld_o | output | 1 | Output symbol is valid |
| dout_re_o | output | DATA_W | Output real field |
| dout_im_o | output | DATA_W | Output imaginary field |

## Verification
Two things can happen in the same cycle on one branch: reading out the old fill value and writing the first live symbol. Likewise, when the selector wraps from the last branch to branch 0, the pass-through path and a stored read happen on back-to-back cycles. The bench provokes both in two phases:
- a run with no stalls, so the fill-to-live boundary and the wrap fall on consecutive cycles;
- a run after a mid-stream reset, with random stalls that carry garbage data.

Each output is compared against a branch-index model of the block. It is also compared against the source sequence after it has passed through a modelled interleaver, which confirms the full `NUM_BR*(NUM_BR-1)*STEP` latency.

// File: rtl/cdi_pkg.sv
package cdi_pkg;

  function automatic int unsigned branch_depth(int unsigned n, int unsigned step, int unsigned j);
    return (n - 1 - j) * step;
  endfunction

  function automatic int unsigned idx_width(int unsigned count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/cdi_commutator.sv
module cdi_commutator #(
  parameter int unsigned NUM_BR = 4,
  parameter int unsigned SEL_W  = cdi_pkg::idx_width(NUM_BR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [SEL_W-1:0] sel_o
);

  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_BR - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_o <= '0;
    else if (adv_i) sel_o <= (sel_o == LAST) ? '0 : sel_o + 1'b1;
  end

  AST_SEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o <= LAST); // R3
  AST_SEL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && sel_o == LAST) |=> (sel_o == '0)); // R3
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(sel_o)); // R4

endmodule

// File: rtl/cdi_branch.sv
module cdi_branch #(
  parameter int unsigned       SYM_W = 16,
  parameter int unsigned       DEPTH = 2,
  parameter logic [SYM_W-1:0]  INIT  = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SYM_W-1:0] din_i,
  output logic [SYM_W-1:0] dout_o
);

  localparam int unsigned PW = cdi_pkg::idx_width(DEPTH);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [SYM_W-1:0] mem [DEPTH];
  logic [PW-1:0]    ptr;

  // read-before-write circular line: oldest entry sits at ptr
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= INIT;
    end else if (en_i) begin
      mem[ptr] <= din_i;
      ptr      <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    end
  end

  assign dout_o = mem[ptr];

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr <= PTR_LAST); // R1
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(ptr)); // R4
  AST_HEAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(dout_o)); // R4

endmodule

// File: rtl/cdi_deinterleaver.sv
module cdi_deinterleaver #(
  parameter int unsigned               NUM_BR      = 4,
  parameter int unsigned               STEP        = 2,
  parameter int unsigned               DATA_W      = 8,
  parameter bit                        USE_SCALAR  = 1'b0,
  parameter logic [2*DATA_W-1:0]       INIT_SCALAR = '0,
  parameter logic [NUM_BR*2*DATA_W-1:0] INIT_VEC   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              din_vld_i,
  input  logic [DATA_W-1:0] din_re_i,
  input  logic [DATA_W-1:0] din_im_i,
  output logic              dout_vld_o,
  output logic [DATA_W-1:0] dout_re_o,
  output logic [DATA_W-1:0] dout_im_o
);

  localparam int unsigned SYM_W = 2 * DATA_W;
  localparam int unsigned SEL_W = cdi_pkg::idx_width(NUM_BR);

  logic [SYM_W-1:0] din_sym;
  logic [SEL_W-1:0] sel;
  logic [SYM_W-1:0] rd [NUM_BR];

  assign din_sym = {din_re_i, din_im_i};

  cdi_commutator #(.NUM_BR(NUM_BR), .SEL_W(SEL_W)) u_comm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (din_vld_i),
    .sel_o (sel)
  );

  for (genvar j = 0; j < int'(NUM_BR); j++) begin : gen_br
    localparam int unsigned DEPTH = cdi_pkg::branch_depth(NUM_BR, STEP, j);
    if (DEPTH == 0) begin : g_pass
      assign rd[j] = din_sym;
    end else begin : g_line
      localparam logic [SYM_W-1:0] INIT_J =
        USE_SCALAR ? INIT_SCALAR : INIT_VEC[j*SYM_W +: SYM_W];
      logic en;
      assign en = din_vld_i && (sel == SEL_W'(j));
      cdi_branch #(.SYM_W(SYM_W), .DEPTH(DEPTH), .INIT(INIT_J)) u_line (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en),
        .din_i (din_sym),
        .dout_o(rd[j])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_vld_o <= 1'b0;
      dout_re_o  <= '0;
      dout_im_o  <= '0;
    end else begin
      dout_vld_o <= din_vld_i;
      if (din_vld_i) {dout_re_o, dout_im_o} <= rd[sel];
    end
  end

  AST_OUT_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    din_vld_i |=> dout_vld_o); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !din_vld_i |=> !dout_vld_o); // R5
  AST_LAST_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (din_vld_i && sel == SEL_W'(NUM_BR - 1)) |=> ({dout_re_o, dout_im_o} == $past(din_sym))); // R2
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !din_vld_i |=> ($stable(dout_re_o) && $stable(dout_im_o))); // R4

endmodule

// File: tb/sim_cdi_deinterleaver.sv
`timescale 1ns/1ps
module sim_cdi_deinterleaver;

  localparam int N    = 4;
  localparam int B    = 2;
  localparam int W    = 8;
  localparam int SW   = 2 * W;
  localparam int LAT  = N * (N - 1) * B;
  localparam int MAXH = 1024;
  localparam logic [N*SW-1:0] IV   = {16'hA4D4, 16'hB3C3, 16'hC2B2, 16'hD1A1};
  localparam logic [SW-1:0]   SC   = 16'h5E6F;
  localparam logic [SW-1:0]   JUNK = 16'h0F1E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [W-1:0] re = '0, im = '0;
  logic v0, v1;
  logic [W-1:0] r0, i0, r1, i1;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [SW-1:0] src [MAXH];
  logic [SW-1:0] hist [MAXH];

  always #10 clk = ~clk;

  cdi_deinterleaver #(.NUM_BR(N), .STEP(B), .DATA_W(W), .USE_SCALAR(1'b0),
    .INIT_SCALAR(SC), .INIT_VEC(IV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .din_vld_i(vld), .din_re_i(re), .din_im_i(im),
    .dout_vld_o(v0), .dout_re_o(r0), .dout_im_o(i0));

  cdi_deinterleaver #(.NUM_BR(N), .STEP(B), .DATA_W(W), .USE_SCALAR(1'b1),
    .INIT_SCALAR(SC), .INIT_VEC(IV)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .din_vld_i(vld), .din_re_i(re), .din_im_i(im),
    .dout_vld_o(v1), .dout_re_o(r1), .dout_im_o(i1));

  function automatic logic [SW-1:0] il_out(int m);
    int d = (m % N) * B * N;
    return (m >= d) ? src[m - d] : JUNK;
  endfunction

  function automatic logic [SW-1:0] dei_exp(int m, bit sc);
    int j = m % N;
    int d = (N - 1 - j) * B * N;
    if (m >= d) return hist[m - d];
    return sc ? SC : IV[j*SW +: SW];
  endfunction

  task automatic check(string tag, logic [SW-1:0] act, logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    vld = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 reset valid u0", {15'd0, v0}, '0);
    check("R5 reset data u0", {r0, i0}, '0);
    check("R5 reset valid u1", {15'd0, v1}, '0);
    rst_n = 1'b1;
  endtask

  task automatic run_phase(int nsym, int stall_pct, int phase);
    int n = 0;
    bit prev_vld = 1'b0;
    int prev_m = 0;
    logic [SW-1:0] last0 = {r0, i0};
    do begin
      @(negedge clk);
      check("R5 valid u0", {15'd0, v0}, {15'd0, prev_vld});
      check("R5 valid u1", {15'd0, v1}, {15'd0, prev_vld});
      if (prev_vld) begin
        int m = prev_m;
        int j = m % N;
        int d = (N - 1 - j) * B * N;
        logic [SW-1:0] e0 = dei_exp(m, 1'b0);
        logic [SW-1:0] e1 = dei_exp(m, 1'b1);
        string tag;
        if (phase == 2 && m < N)  tag = "R10";
        else if (j == N - 1)      tag = "R2";
        else if (m < d)           tag = "R6";
        else if (j == 0)          tag = "R3";
        else                      tag = "R1";
        check({tag, " re u0"}, {8'd0, r0}, {8'd0, e0[SW-1:W]});
        check("R9 im u0", {8'd0, i0}, {8'd0, e0[W-1:0]});
        check((m < d) ? "R7 u1" : "R1 u1", {r1, i1}, e1);
        if (m >= LAT) check("R8 end-to-end", {r0, i0}, src[m - LAT]);
      end else begin
        check("R4 hold u0", {r0, i0}, last0);
      end
      last0 = {r0, i0};
      if (n < nsym && int'($urandom % 100) >= stall_pct) begin
        src[n]  = SW'($urandom);
        hist[n] = il_out(n);
        {re, im} = hist[n];
        vld = 1'b1;
        prev_m = n;
        n++;
        prev_vld = 1'b1;
      end else begin
        vld = 1'b0;
        {re, im} = SW'($urandom);
        prev_vld = 1'b0;
      end
    end while (n < nsym || prev_vld);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    do_reset();
    run_phase(300, 0, 1);
    // stall burst with garbage data
    repeat (20) begin
      @(negedge clk);
      vld = 1'b0;
      {re, im} = SW'($urandom);
      check("R4 burst hold u0", {15'd0, v0}, '0);
    end
    do_reset();
    run_phase(400, 40, 2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule